// File: doc/BRIEF.md
# March and Checkerboard Memory Self-Test Engine

This block tests one synchronous single-port SRAM on chip without outside help. While the test-select input is low, the memory port muxes pass the functional address, data and enables straight through. When test-select goes high, the engine takes over the memory port and runs one pass of the chosen algorithm. The choices are four march variants of increasing strength and a two-group checkerboard. Every read is checked against the value the algorithm expects, and the block raises a done flag and a fail flag at the end of the pass.

Each march element walks the whole address space once. Elements with an even index count up and elements with an odd index count down. Within an element, each address gets one or two operations, one per clock. The memory returns read data one cycle after a read is issued, so the expected value is held for one cycle before the compare. A retention pause of programmable length can be placed after the initial write element of the March C and checkerboard passes. The first mismatch records its address and element index. Those records and the fail flag hold until the self-test reset.

Top module: `mem_selftest`

## Requirements
- R1: While `bist_rst` is high at a rising edge, the engine goes idle and `done`, `fail`, `fail_addr` and `fail_elem` are cleared to zero from the next cycle.
- R2: While `test_sel` is low, `mem_addr`, `mem_wdata`, `mem_we` and `mem_re` equal `fn_addr`, `fn_wdata`, `fn_we` and `fn_re`. One edge after `test_sel` is sampled low, the engine is idle and `done` is low.
- R3: `alg_sel` picks the pass: 0 is MATS (w0; r0,w1; r1), 1 is MATS+ (w0; r0,w1; r1,w0), 2 is March X (w0; r0,w1; r1,w0; r0), 3 is March C (w0; r0,w1; r1,w0; r0,w1; r1,w0; r0) and 4 is checkerboard (w0; r0). Codes 5 to 7 run March C. Exactly one memory operation is issued per cycle, in element order, and every operation of an element is done at one address before the next address is visited.
- R4: Element index e (starting at 0) visits addresses 0 up to 2^AW-1 when e is even, and 2^AW-1 down to 0 when e is odd.
- R5: A write of value v puts all DW bits at v. In checkerboard mode, v is XORed with the cell group g = addr[0] XOR addr[CB] (just addr[0] when CB is 0). Group 1 cells therefore receive all ones and group 0 cells receive all zeros, and the read element expects the same word back.
- R6: `mem_rdata` is compared in the cycle after the read is issued. Any bit that differs from the expected word sets `fail`.
- R7: With no pause, `done` rises K*2^AW+2 rising edges after the edge that first samples `test_sel` high from idle. K is the number of operations per address in the pass. `done` stays high until `test_sel` goes low or reset. `done` and the final compare result become visible in the same cycle.
- R8: When `ret_en` is high and `pause_len` is P > 0 at start, March C (codes 3, 5 to 7) and checkerboard insert exactly P cycles with no memory access after element 0. The other passes ignore `ret_en`.
- R9: `fail` is sticky. Once set, it stays high through `test_sel` changes and later passes until `bist_rst`.
- R10: `fail_addr` and `fail_elem` record the address and element index of the first mismatch since reset. Later mismatches do not change them.
- R11: `alg_sel`, `ret_en` and `pause_len` are sampled when a pass starts. Changing them during the pass has no effect on that pass.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock |
| bist_rst | input | 1 | Synchronous active-high reset of the self-test logic |
| test_sel | input | 1 | High: engine owns the memory port and runs a pass; low: functional pass-through |
| alg_sel | input | 3 | Algorithm code (see R3) |
| ret_en | input | 1 | Enables the retention pause |
| pause_len | input | PW | Pause length in cycles |
| fn_addr | input | AW | Functional address |
| fn_wdata | input | DW | Functional write data |
| fn_we | input | 1 | Functional write enable |
| fn_re | input | 1 | Functional read enable |
| mem_addr | output | AW | Address to the SRAM |
| mem_wdata | output | DW | Write data to the SRAM |
| mem_we | output | 1 | Write enable to the SRAM |
| mem_re | output | 1 | Read enable to the SRAM |
| mem_rdata | input | DW | SRAM read data, one cycle after `mem_re` |
| done | output | 1 | Pass complete |
| fail | output | 1 | Sticky mismatch flag |
| fail_addr | output | AW | Address of the first mismatch |
| fail_elem | output | 3 | Element index of the first mismatch |

## Verification
The assertions assume three things about the inputs. The SRAM returns read data exactly one clock after `mem_re`. `bist_rst` is high from time zero. `test_sel` is dropped only between passes. The bench keeps within these limits. Its memory model registers read data on the edge that samples `mem_re`, it holds reset over the first edges, and it lowers `test_sel` only after `done` has been seen. Faults are stuck-at bits injected on the model's write path, so the operation stream stays exactly as the requirements predict while the read-back data goes wrong.

// File: rtl/mst_pkg.sv
package mst_pkg;

  localparam logic [2:0] ALG_MATS   = 3'd0;
  localparam logic [2:0] ALG_MATSP  = 3'd1;
  localparam logic [2:0] ALG_MARCHX = 3'd2;
  localparam logic [2:0] ALG_MARCHC = 3'd3;
  localparam logic [2:0] ALG_CKBD   = 3'd4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RUN, ST_PAUSE, ST_FLUSH, ST_DONE
  } st_e;

  // One march element: up to two operations per address
  typedef struct packed {
    logic two;  // second operation present
    logic rd0;  // first op is a read
    logic v0;   // first op data bit
    logic rd1;  // second op is a read
    logic v1;   // second op data bit
  } elem_t;

  localparam elem_t E_W0   = 5'b0_0_0_0_0;
  localparam elem_t E_R0   = 5'b0_1_0_0_0;
  localparam elem_t E_R1   = 5'b0_1_1_0_0;
  localparam elem_t E_R0W1 = 5'b1_1_0_0_1;
  localparam elem_t E_R1W0 = 5'b1_1_1_0_0;

  // Map unused codes onto March C
  function automatic logic [2:0] norm_alg(input logic [2:0] a);
    return (a > ALG_CKBD) ? ALG_MARCHC : a;
  endfunction

  function automatic logic [2:0] elem_count(input logic [2:0] a);
    case (a)
      ALG_MATS:   return 3'd3;
      ALG_MATSP:  return 3'd3;
      ALG_MARCHX: return 3'd4;
      ALG_CKBD:   return 3'd2;
      default:    return 3'd6;
    endcase
  endfunction

  function automatic elem_t elem_desc(input logic [2:0] a, input logic [2:0] idx);
    elem_t e;
    e = E_W0;
    if (idx != 3'd0) begin
      case (a)
        ALG_MATS:   e = (idx == 3'd1) ? E_R0W1 : E_R1;
        ALG_MATSP:  e = (idx == 3'd1) ? E_R0W1 : E_R1W0;
        ALG_MARCHX: e = (idx == 3'd1) ? E_R0W1 : (idx == 3'd2) ? E_R1W0 : E_R0;
        ALG_CKBD:   e = E_R0;
        default: begin
          case (idx)
            3'd1, 3'd3: e = E_R0W1;
            3'd2, 3'd4: e = E_R1W0;
            default:    e = E_R0;
          endcase
        end
      endcase
    end
    return e;
  endfunction

  // Odd elements walk downward
  function automatic logic elem_down(input logic [2:0] idx);
    return idx[0];
  endfunction

  // Retention pause sits after the initial write element
  function automatic logic pause_after(input logic [2:0] a, input logic [2:0] idx);
    return (idx == 3'd0) && ((a == ALG_MARCHC) || (a == ALG_CKBD));
  endfunction

  // Checkerboard group: row LSB xor column LSB
  function automatic logic ckbd_group(input logic [31:0] addr, input int cb);
    if (cb == 0) return addr[0];
    return addr[0] ^ addr[cb];
  endfunction

endpackage

// File: rtl/mst_seq.sv
module mst_seq
  import mst_pkg::*;
#(
  parameter int AW = 6,
  parameter int PW = 24,
  parameter int CB = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          test_sel,
  input  logic [2:0]    alg_sel,
  input  logic          ret_en,
  input  logic [PW-1:0] pause_len,
  output logic          issue_vld,
  output logic          issue_rd,
  output logic [AW-1:0] issue_addr,
  output logic          issue_bit,
  output logic [2:0]    issue_elem,
  output logic          pause_act,
  output logic          seq_done
);

  localparam logic [AW-1:0] ADDR_LAST = {AW{1'b1}};

  st_e           state;
  logic [2:0]    alg_q;
  logic          ret_q;
  logic [PW-1:0] plen_q;
  logic [PW-1:0] cnt_q;
  logic [2:0]    elem_q;
  logic [AW-1:0] addr_q;
  logic          op_q;

  elem_t      desc;
  logic       down, cur_rd, cur_v, grp;
  logic       op_end, addr_end, seq_last, take_pause;
  logic [2:0] elem_nx;

  always_comb begin
    desc       = elem_desc(alg_q, elem_q);
    down       = elem_down(elem_q);
    cur_rd     = op_q ? desc.rd1 : desc.rd0;
    cur_v      = op_q ? desc.v1  : desc.v0;
    grp        = ckbd_group(32'(addr_q), CB);
    op_end     = !(desc.two && !op_q);
    addr_end   = down ? (addr_q == '0) : (addr_q == ADDR_LAST);
    seq_last   = (elem_q == elem_count(alg_q) - 3'd1);
    take_pause = pause_after(alg_q, elem_q) && ret_q && (plen_q != '0);
    elem_nx    = elem_q + 3'd1;
  end

  assign issue_vld  = (state == ST_RUN) && test_sel;
  assign issue_rd   = issue_vld && cur_rd;
  assign issue_addr = addr_q;
  assign issue_bit  = cur_v ^ ((alg_q == ALG_CKBD) && grp);
  assign issue_elem = elem_q;
  assign pause_act  = (state == ST_PAUSE);
  assign seq_done   = (state == ST_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      alg_q  <= '0;
      ret_q  <= 1'b0;
      plen_q <= '0;
      cnt_q  <= '0;
      elem_q <= '0;
      addr_q <= '0;
      op_q   <= 1'b0;
    end else if (!test_sel) begin
      state <= ST_IDLE;
      op_q  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          state  <= ST_RUN;
          alg_q  <= norm_alg(alg_sel);
          ret_q  <= ret_en;
          plen_q <= pause_len;
          elem_q <= '0;
          addr_q <= '0;
          op_q   <= 1'b0;
        end
        ST_RUN: begin
          if (!op_end) begin
            op_q <= 1'b1;
          end else begin
            op_q <= 1'b0;
            if (!addr_end) begin
              addr_q <= down ? addr_q - 1'b1 : addr_q + 1'b1;
            end else if (seq_last) begin
              state <= ST_FLUSH;
            end else begin
              elem_q <= elem_nx;
              addr_q <= elem_down(elem_nx) ? ADDR_LAST : '0;
              if (take_pause) begin
                state <= ST_PAUSE;
                cnt_q <= plen_q - 1'b1;
              end
            end
          end
        end
        ST_PAUSE: begin
          if (cnt_q == '0) state <= ST_RUN;
          else             cnt_q <= cnt_q - 1'b1;
        end
        ST_FLUSH: state <= ST_DONE;
        default:  state <= ST_DONE;
      endcase
    end
  end

endmodule

// File: rtl/mst_cmp.sv
module mst_cmp #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue_rd,
  input  logic [AW-1:0] issue_addr,
  input  logic [2:0]    issue_elem,
  input  logic          issue_bit,
  input  logic [DW-1:0] mem_rdata,
  output logic          mismatch,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic [2:0]    fail_elem
);

  logic          pend_q;
  logic          exp_q;
  logic [AW-1:0] addr_q;
  logic [2:0]    elem_q;

  // Expected word trails the read by the memory latency
  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      exp_q  <= 1'b0;
      addr_q <= '0;
      elem_q <= '0;
    end else begin
      pend_q <= issue_rd;
      exp_q  <= issue_bit;
      addr_q <= issue_addr;
      elem_q <= issue_elem;
    end
  end

  assign mismatch = pend_q && (mem_rdata != {DW{exp_q}});

  always_ff @(posedge clk) begin
    if (rst) begin
      fail      <= 1'b0;
      fail_addr <= '0;
      fail_elem <= '0;
    end else if (mismatch && !fail) begin
      fail      <= 1'b1;
      fail_addr <= addr_q;
      fail_elem <= elem_q;
    end
  end

endmodule

// File: rtl/mst_mux.sv
module mst_mux #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          test_sel,
  input  logic [AW-1:0] fn_addr,
  input  logic [DW-1:0] fn_wdata,
  input  logic          fn_we,
  input  logic          fn_re,
  input  logic          t_vld,
  input  logic          t_rd,
  input  logic [AW-1:0] t_addr,
  input  logic          t_bit,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re
);

  always_comb begin
    if (test_sel) begin
      mem_addr  = t_addr;
      mem_wdata = {DW{t_bit}};
      mem_we    = t_vld && !t_rd;
      mem_re    = t_vld && t_rd;
    end else begin
      mem_addr  = fn_addr;
      mem_wdata = fn_wdata;
      mem_we    = fn_we;
      mem_re    = fn_re;
    end
  end

endmodule

// File: rtl/mem_selftest.sv
module mem_selftest #(
  parameter int AW = 6,
  parameter int DW = 16,
  parameter int CB = 3,
  parameter int PW = 24
) (
  input  logic          clk,
  input  logic          bist_rst,
  input  logic          test_sel,
  input  logic [2:0]    alg_sel,
  input  logic          ret_en,
  input  logic [PW-1:0] pause_len,
  input  logic [AW-1:0] fn_addr,
  input  logic [DW-1:0] fn_wdata,
  input  logic          fn_we,
  input  logic          fn_re,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  input  logic [DW-1:0] mem_rdata,
  output logic          done,
  output logic          fail,
  output logic [AW-1:0] fail_addr,
  output logic [2:0]    fail_elem
);

  logic          issue_vld, issue_rd, issue_bit;
  logic [AW-1:0] issue_addr;
  logic [2:0]    issue_elem;
  logic          pause_act;
  logic          mismatch;

  mst_seq #(.AW(AW), .PW(PW), .CB(CB)) u_seq (
    .clk        (clk),
    .rst        (bist_rst),
    .test_sel   (test_sel),
    .alg_sel    (alg_sel),
    .ret_en     (ret_en),
    .pause_len  (pause_len),
    .issue_vld  (issue_vld),
    .issue_rd   (issue_rd),
    .issue_addr (issue_addr),
    .issue_bit  (issue_bit),
    .issue_elem (issue_elem),
    .pause_act  (pause_act),
    .seq_done   (done)
  );

  mst_cmp #(.AW(AW), .DW(DW)) u_cmp (
    .clk        (clk),
    .rst        (bist_rst),
    .issue_rd   (issue_rd),
    .issue_addr (issue_addr),
    .issue_elem (issue_elem),
    .issue_bit  (issue_bit),
    .mem_rdata  (mem_rdata),
    .mismatch   (mismatch),
    .fail       (fail),
    .fail_addr  (fail_addr),
    .fail_elem  (fail_elem)
  );

  mst_mux #(.AW(AW), .DW(DW)) u_mux (
    .test_sel  (test_sel),
    .fn_addr   (fn_addr),
    .fn_wdata  (fn_wdata),
    .fn_we     (fn_we),
    .fn_re     (fn_re),
    .t_vld     (issue_vld),
    .t_rd      (issue_rd),
    .t_addr    (issue_addr),
    .t_bit     (issue_bit),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_we    (mem_we),
    .mem_re    (mem_re)
  );

endmodule

// File: rtl/mem_selftest_chk.sv
module mem_selftest_chk #(
  parameter int AW = 6
) (
  input logic          clk,
  input logic          bist_rst,
  input logic          test_sel,
  input logic          done,
  input logic          fail,
  input logic [AW-1:0] fail_addr,
  input logic [2:0]    fail_elem,
  input logic          mem_we,
  input logic          mem_re,
  input logic          pause_act,
  input logic          mismatch
);

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    bist_rst |=> !done && !fail);

  // R2
  idle_done_low_chk: assert property (@(posedge clk) disable iff (bist_rst)
    !test_sel |=> !done);

  // R3
  one_access_chk: assert property (@(posedge clk) disable iff (bist_rst)
    test_sel |-> $onehot0({mem_we, mem_re}));

  // R6
  mismatch_sets_fail_chk: assert property (@(posedge clk) disable iff (bist_rst)
    mismatch |=> fail);

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (bist_rst)
    done && test_sel |=> done);

  // R8
  pause_quiet_chk: assert property (@(posedge clk) disable iff (bist_rst)
    pause_act |-> !mem_we && !mem_re);

  // R9
  fail_sticky_chk: assert property (@(posedge clk) disable iff (bist_rst)
    fail |=> fail);

  // R10
  first_fail_hold_chk: assert property (@(posedge clk) disable iff (bist_rst)
    fail |=> $stable(fail_addr) && $stable(fail_elem));

endmodule

bind mem_selftest mem_selftest_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .bist_rst  (bist_rst),
  .test_sel  (test_sel),
  .done      (done),
  .fail      (fail),
  .fail_addr (fail_addr),
  .fail_elem (fail_elem),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .pause_act (pause_act),
  .mismatch  (mismatch)
);

// File: tb/mem_selftest_test.sv
module mem_selftest_test;

  localparam int AW = 4;
  localparam int DW = 8;
  localparam int CB = 2;
  localparam int PW = 8;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          bist_rst, test_sel, ret_en, fn_we, fn_re;
  logic [2:0]    alg_sel;
  logic [PW-1:0] pause_len;
  logic [AW-1:0] fn_addr, mem_addr, fail_addr;
  logic [DW-1:0] fn_wdata, mem_wdata, mem_rdata;
  logic          mem_we, mem_re, done, fail;
  logic [2:0]    fail_elem;

  always #5 clk = ~clk;

  mem_selftest #(.AW(AW), .DW(DW), .CB(CB), .PW(PW)) uut (
    .clk(clk), .bist_rst(bist_rst), .test_sel(test_sel), .alg_sel(alg_sel),
    .ret_en(ret_en), .pause_len(pause_len), .fn_addr(fn_addr),
    .fn_wdata(fn_wdata), .fn_we(fn_we), .fn_re(fn_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
    .mem_rdata(mem_rdata), .done(done), .fail(fail), .fail_addr(fail_addr),
    .fail_elem(fail_elem)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Memory model: one-cycle read latency, stuck-at fault on the write path
  logic [DW-1:0] mem [N];
  logic [DW-1:0] rdq = '0;
  bit f_on = 0;
  int f_addr = 0;
  int f_bit = 0;
  bit f_val = 0;

  function automatic logic [DW-1:0] store_val(input logic [AW-1:0] a, input logic [DW-1:0] d);
    logic [DW-1:0] r;
    r = d;
    if (f_on && int'(a) == f_addr) r[f_bit] = f_val;
    return r;
  endfunction

  initial for (int i = 0; i < N; i++) mem[i] = '0;

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= store_val(mem_addr, mem_wdata);
    if (mem_re) rdq <= mem[mem_addr];
  end
  assign mem_rdata = rdq;

  // Scoreboard of expected memory operations
  typedef struct {
    bit            wr;
    int            addr;
    logic [DW-1:0] data;
  } op_t;
  op_t q[$];
  op_t cur;

  function automatic int nelem(input int na);
    case (na)
      0: return 3;
      1: return 3;
      2: return 4;
      4: return 2;
      default: return 6;
    endcase
  endfunction

  // codes: 0 w0, 1 w1, 2 r0, 3 r1, -1 none
  function automatic int opc(input int na, input int e, input int k);
    int a0, a1;
    a0 = -1; a1 = -1;
    if (e == 0) a0 = 0;
    else begin
      case (na)
        0: if (e == 1) begin a0 = 2; a1 = 1; end else a0 = 3;
        1: if (e == 1) begin a0 = 2; a1 = 1; end else begin a0 = 3; a1 = 0; end
        2: if (e == 1) begin a0 = 2; a1 = 1; end
           else if (e == 2) begin a0 = 3; a1 = 0; end
           else a0 = 2;
        4: a0 = 2;
        default:
          if (e == 1 || e == 3) begin a0 = 2; a1 = 1; end
          else if (e == 2 || e == 4) begin a0 = 3; a1 = 0; end
          else a0 = 2;
      endcase
    end
    return (k == 0) ? a0 : a1;
  endfunction

  task automatic push_ops(input int na);
    for (int e = 0; e < nelem(na); e++) begin
      for (int i = 0; i < N; i++) begin
        int a;
        a = (e % 2 == 1) ? N - 1 - i : i;
        for (int k = 0; k < 2; k++) begin
          int c;
          bit v;
          op_t o;
          c = opc(na, e, k);
          if (c >= 0) begin
            v = c[0];
            if (na == 4) v = v ^ (a[0] ^ a[CB]);
            o.wr = (c < 2);
            o.addr = a;
            o.data = {DW{v}};
            q.push_back(o);
          end
        end
      end
    end
  endtask

  // Monitor: compare each engine access against the queue head
  always @(negedge clk) begin
    if (test_sel && (mem_we || mem_re)) begin
      if (q.size() == 0) begin
        chk(0, "R3", "access with empty queue", 1, 0);
      end else begin
        cur = q.pop_front();
        chk(mem_we == cur.wr && mem_re == !cur.wr, "R3", "op kind (1=write)",
            mem_we, cur.wr);
        chk(int'(mem_addr) == cur.addr, "R4", "address", mem_addr, cur.addr);
        if (cur.wr)
          chk(mem_wdata == cur.data, "R5", "write data", mem_wdata, cur.data);
      end
    end
  end

  task automatic run_pass(input int alg, input bit ret, input int p,
                          input bit chg, input string tag);
    int na, cyc, expc;
    na = (alg > 4) ? 3 : alg;
    q.delete();
    push_ops(na);
    expc = q.size() + 2 + ((ret && p > 0 && (na == 3 || na == 4)) ? p : 0);
    alg_sel = alg[2:0];
    ret_en = ret;
    pause_len = p[PW-1:0];
    test_sel = 1'b1;
    cyc = 0;
    do begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (chg && cyc == 5) begin
        alg_sel = 3'd0;
        ret_en = ~ret;
        pause_len = 8'd50;
      end
    end while (!done && cyc < 4000);
    chk(cyc == expc, tag, "edges until done", cyc, expc);
    chk(q.size() == 0, tag, "expected ops left over", q.size(), 0);
    test_sel = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(done == 1'b0, "R2", "done after test_sel low", done, 0);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "watchdog", "run did not end", 0, 1);
    summary();
  end

  initial begin
    bist_rst = 1'b1; test_sel = 1'b0; alg_sel = '0; ret_en = 1'b0;
    pause_len = '0; fn_addr = '0; fn_wdata = '0; fn_we = 1'b0; fn_re = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    bist_rst = 1'b0;
    chk(done == 0 && fail == 0, "R1", "done/fail after reset", {done, fail}, 0);
    chk(fail_addr == 0 && fail_elem == 0, "R1", "capture after reset",
        {fail_elem, fail_addr}, 0);

    // R2 functional pass-through
    fn_addr = 4'd9; fn_wdata = 8'hA5; fn_we = 1'b1; fn_re = 1'b0;
    #1;
    chk(mem_addr == 4'd9 && mem_wdata == 8'hA5 && mem_we && !mem_re, "R2",
        "pass-through pattern 1", {mem_we, mem_re, mem_wdata, mem_addr},
        {1'b1, 1'b0, 8'hA5, 4'd9});
    fn_addr = 4'd3; fn_wdata = 8'h3C; fn_we = 1'b0; fn_re = 1'b1;
    #1;
    chk(mem_addr == 4'd3 && mem_wdata == 8'h3C && !mem_we && mem_re, "R2",
        "pass-through pattern 2", {mem_we, mem_re, mem_wdata, mem_addr},
        {1'b0, 1'b1, 8'h3C, 4'd3});
    fn_we = 1'b0; fn_re = 1'b0;
    @(negedge clk);
    chk(done == 0, "R2", "done while not testing", done, 0);

    // Clean passes: R3 R4 R5 R7
    run_pass(0, 0, 0, 0, "R7 MATS");
    run_pass(1, 0, 0, 0, "R7 MATS+");
    run_pass(2, 0, 0, 0, "R7 MarchX");
    run_pass(3, 0, 0, 0, "R7 MarchC");
    run_pass(4, 0, 0, 0, "R5 checkerboard");
    run_pass(6, 0, 0, 0, "R3 code6");
    chk(fail == 0, "R6", "no fail on fault-free memory", fail, 0);

    // Retention pause
    run_pass(3, 1, 20, 0, "R8 MarchC pause");
    run_pass(4, 1, 7, 0, "R8 checkerboard pause");
    run_pass(0, 1, 20, 0, "R8 MATS ignores pause");
    run_pass(3, 1, 0, 0, "R8 zero pause");

    // Inputs changed mid-pass
    run_pass(3, 0, 0, 1, "R11 mid-pass change");
    chk(fail == 0, "R6", "still no fail", fail, 0);

    // Stuck-at-0 bit 3 at address 5: first seen in element 2
    f_on = 1; f_addr = 5; f_bit = 3; f_val = 0;
    run_pass(3, 0, 0, 0, "R6 fault pass");
    chk(fail == 1, "R6", "fail after stuck-at-0", fail, 1);
    chk(fail_addr == 5, "R10", "first fail address", fail_addr, 5);
    chk(fail_elem == 2, "R10", "first fail element", fail_elem, 2);
    repeat (3) @(negedge clk);
    chk(fail == 1, "R9", "fail held with test_sel low", fail, 1);

    // Different fault, no reset: capture must not move
    f_addr = 12; f_bit = 0; f_val = 1;
    run_pass(3, 0, 0, 0, "R9 second fault pass");
    chk(fail == 1, "R9", "fail held across passes", fail, 1);
    chk(fail_addr == 5 && fail_elem == 2, "R10", "capture kept (elem*16+addr)",
        fail_elem * 16 + fail_addr, 2 * 16 + 5);

    // Reset clears; checkerboard fault at group-0 address 10
    bist_rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    bist_rst = 1'b0;
    chk(fail == 0 && fail_addr == 0 && fail_elem == 0, "R1",
        "capture cleared by reset", {fail, fail_elem, fail_addr}, 0);
    f_addr = 10; f_bit = 0; f_val = 1;
    run_pass(4, 0, 0, 0, "R5 checkerboard fault pass");
    chk(fail == 1, "R6", "checkerboard fail", fail, 1);
    chk(fail_addr == 10 && fail_elem == 1, "R10", "checkerboard capture (elem*16+addr)",
        fail_elem * 16 + fail_addr, 1 * 16 + 10);

    summary();
  end

endmodule